// File: doc/BRIEF.md
# Programmable Line-Sensor Timing Generator

This block generates the repeating strobes needed by a linear image sensor and by the analog front end that digitises it. Three modulo counters set the timing. A fine "dot" counter and a "pixel" counter both count master-clock cycles. A 16-bit line counter steps once every time the pixel counter wraps. Each output strobe has a programmable rise position and fall position, and each position is compared against the counter that the strobe belongs to.

Firmware programs the periods and edge positions through a byte-wide register port, then raises the enable. A two-state controller sequences the block. In state `ST_IDLE` the counters and strobe flops are held at zero, and the working copies of the period registers follow the programmed values. The transition `ST_IDLE -> ST_RUN` happens on the first clock with `en` high. In state `ST_RUN` the counters advance. The transition `ST_RUN -> ST_IDLE` happens on the first clock with `en` low. A mask can hold any strobe at its inactive (low) level while the counters keep running.

Top module: `ccd_timing_gen`

## Requirements
- R1: After reset, every register reads 0 and every strobe output is low.
- R2: Register map. 0x00 is the dot period, 0x01 the pixel period, 0x02/0x03 the line period high/low byte, 0x04/0x05 the ADCLK rise/fall, 0x06/0x07 the SH rise high/low, 0x08/0x09 the SH fall high/low, 0x0A/0x0B the LED rise high/low, 0x0C/0x0D the LED fall high/low, and 0x0E/0x0F the mask low/high byte. For strobe i (0=RS1, 1=RS2, 2=SHR, 3=SHS, 4=H1, 5=H2, 6=CLAMP), address 0x10+2i holds the rise and 0x11+2i holds the fall. Every 6-bit register keeps bits 5:0 of a write and reads bits 7:6 as 0. Unmapped addresses read 0.
- R3: The dot counter runs through 0..N and wraps, so its period is N+1 master clocks. ADCLK goes high on the clock after the dot count equals the ADCLK rise value. It goes low on the clock after the count equals the fall value.
- R4: The pixel counter has a period of N+1 master clocks. RS1, RS2, SHR, SHS, H1, H2 and CLAMP each compare their 6-bit rise and fall against it. A rise value larger than the fall value gives a pulse that spans the wrap.
- R5: The line counter steps when the pixel counter wraps. Its period is N+1 pixel periods, where N = {high byte, low byte}. SH and LED compare their 16-bit rise and fall against it.
- R6: When a strobe's rise value equals its fall value, that strobe stays low.
- R7: A new period value takes effect only when the affected counter next wraps. The period that is under way completes with the old value.
- R8: Mask bit k forces output k low. Bit 0 is ADCLK, 1 SH, 2 LED, 3 RS1, 4 RS2, 5 SHR, 6 SHS and 7 H1, all in 0x0E. H2 and CLAMP are bits 0 and 1 of 0x0F, whose bits 7:2 read 0.
- R9: With `en` low, the counters are held at 0. All outputs are low from the second clock after `en` falls. After `en` rises, the counters begin at 0 on the next clock, and a strobe with rise value 0 is high in the clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block run enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| adclk | output | 1 | Front-end conversion clock |
| sh | output | 1 | Sensor transfer pulse |
| led | output | 1 | Illumination enable |
| rs1 | output | 1 | Reset strobe 1 |
| rs2 | output | 1 | Reset strobe 2 |
| shr | output | 1 | Reset-level sample strobe |
| shs | output | 1 | Signal-level sample strobe |
| h1 | output | 1 | Shift clock phase 1 |
| h2 | output | 1 | Shift clock phase 2 |
| clamp | output | 1 | Black-level clamp |

## Verification
The strobes are driven with several edge patterns:
- a pulse placed inside the period;
- a pulse that wraps around the counter's end;
- a near-full-duty pulse;
- equal rise and fall positions.

Counting the high cycles over a whole number of periods tells apart errors in period length, edge ordering and edge polarity. A short line period and a 257-pixel line period check both bytes of the line period and the step of the line counter on each pixel wrap. An exact cycle-by-cycle restart after enable fixes the one-clock latency of the strobe flops. Changing the pixel period right after a pulse shows whether the old period completes before the new one applies.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;
    localparam int unsigned FINE_W  = 6;
    localparam int unsigned LINE_W  = 16;
    localparam int unsigned NUM_PIX = 7;
    localparam int unsigned NUM_OUT = 10;

    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} tg_state_e;

    localparam logic [7:0] A_DOT_PER  = 8'h00;
    localparam logic [7:0] A_PIX_PER  = 8'h01;
    localparam logic [7:0] A_LINE_HI  = 8'h02;
    localparam logic [7:0] A_LINE_LO  = 8'h03;
    localparam logic [7:0] A_ADC_RISE = 8'h04;
    localparam logic [7:0] A_ADC_FALL = 8'h05;
    localparam logic [7:0] A_SHR_HI   = 8'h06;
    localparam logic [7:0] A_SHR_LO   = 8'h07;
    localparam logic [7:0] A_SHF_HI   = 8'h08;
    localparam logic [7:0] A_SHF_LO   = 8'h09;
    localparam logic [7:0] A_LDR_HI   = 8'h0A;
    localparam logic [7:0] A_LDR_LO   = 8'h0B;
    localparam logic [7:0] A_LDF_HI   = 8'h0C;
    localparam logic [7:0] A_LDF_LO   = 8'h0D;
    localparam logic [7:0] A_MASK_LO  = 8'h0E;
    localparam logic [7:0] A_MASK_HI  = 8'h0F;
    localparam logic [7:0] A_PIX_BASE = 8'h10;
endpackage

// File: rtl/ccd_tg_count.sv
module ccd_tg_count #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         step,
    input  logic [W-1:0] per_in,
    output logic [W-1:0] cnt,
    output logic [W-1:0] per_act,
    output logic         wrap
);
    assign wrap = run && step && (cnt == per_act);

    // working period: tracks the register while idle, reloads only on wrap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_act <= '0;
        end else if (!run || wrap) begin
            per_act <= per_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ccd_tg_edge.sv
module ccd_tg_edge #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] fall,
    output logic         q
);
    // fall wins over rise, so equal positions keep the strobe low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (!run) begin
            q <= 1'b0;
        end else if (cnt == fall) begin
            q <= 1'b0;
        end else if (cnt == rise) begin
            q <= 1'b1;
        end
    end
endmodule

// File: rtl/ccd_tg_regs.sv
module ccd_tg_regs
    import ccd_tg_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [7:0]                     addr,
    input  logic [7:0]                     wdata,
    output logic [7:0]                     rdata,
    output logic [FINE_W-1:0]              dot_per,
    output logic [FINE_W-1:0]              pix_per,
    output logic [LINE_W-1:0]              line_per,
    output logic [FINE_W-1:0]              adc_rise,
    output logic [FINE_W-1:0]              adc_fall,
    output logic [LINE_W-1:0]              sh_rise,
    output logic [LINE_W-1:0]              sh_fall,
    output logic [LINE_W-1:0]              led_rise,
    output logic [LINE_W-1:0]              led_fall,
    output logic [NUM_OUT-1:0]             mask,
    output logic [NUM_PIX-1:0][FINE_W-1:0] pr_rise,
    output logic [NUM_PIX-1:0][FINE_W-1:0] pr_fall
);
    localparam int unsigned PADF = 8 - FINE_W;
    localparam int unsigned PADM = 16 - NUM_OUT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dot_per  <= '0;
            pix_per  <= '0;
            line_per <= '0;
            adc_rise <= '0;
            adc_fall <= '0;
            sh_rise  <= '0;
            sh_fall  <= '0;
            led_rise <= '0;
            led_fall <= '0;
            mask     <= '0;
        end else if (we) begin
            case (addr)
                A_DOT_PER:  dot_per        <= wdata[FINE_W-1:0];
                A_PIX_PER:  pix_per        <= wdata[FINE_W-1:0];
                A_LINE_HI:  line_per[15:8] <= wdata;
                A_LINE_LO:  line_per[7:0]  <= wdata;
                A_ADC_RISE: adc_rise       <= wdata[FINE_W-1:0];
                A_ADC_FALL: adc_fall       <= wdata[FINE_W-1:0];
                A_SHR_HI:   sh_rise[15:8]  <= wdata;
                A_SHR_LO:   sh_rise[7:0]   <= wdata;
                A_SHF_HI:   sh_fall[15:8]  <= wdata;
                A_SHF_LO:   sh_fall[7:0]   <= wdata;
                A_LDR_HI:   led_rise[15:8] <= wdata;
                A_LDR_LO:   led_rise[7:0]  <= wdata;
                A_LDF_HI:   led_fall[15:8] <= wdata;
                A_LDF_LO:   led_fall[7:0]  <= wdata;
                A_MASK_LO:  mask[7:0]      <= wdata;
                A_MASK_HI:  mask[NUM_OUT-1:8] <= wdata[NUM_OUT-9:0];
                default: ;
            endcase
        end
    end

    for (genvar gi = 0; gi < NUM_PIX; gi++) begin : g_pix_reg
        localparam logic [7:0] A_R = 8'(A_PIX_BASE + 2 * gi);
        localparam logic [7:0] A_F = 8'(A_PIX_BASE + 2 * gi + 1);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pr_rise[gi] <= '0;
                pr_fall[gi] <= '0;
            end else if (we && addr == A_R) begin
                pr_rise[gi] <= wdata[FINE_W-1:0];
            end else if (we && addr == A_F) begin
                pr_fall[gi] <= wdata[FINE_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_DOT_PER:  rdata = {{PADF{1'b0}}, dot_per};
            A_PIX_PER:  rdata = {{PADF{1'b0}}, pix_per};
            A_LINE_HI:  rdata = line_per[15:8];
            A_LINE_LO:  rdata = line_per[7:0];
            A_ADC_RISE: rdata = {{PADF{1'b0}}, adc_rise};
            A_ADC_FALL: rdata = {{PADF{1'b0}}, adc_fall};
            A_SHR_HI:   rdata = sh_rise[15:8];
            A_SHR_LO:   rdata = sh_rise[7:0];
            A_SHF_HI:   rdata = sh_fall[15:8];
            A_SHF_LO:   rdata = sh_fall[7:0];
            A_LDR_HI:   rdata = led_rise[15:8];
            A_LDR_LO:   rdata = led_rise[7:0];
            A_LDF_HI:   rdata = led_fall[15:8];
            A_LDF_LO:   rdata = led_fall[7:0];
            A_MASK_LO:  rdata = mask[7:0];
            A_MASK_HI:  rdata = {{PADM{1'b0}}, mask[NUM_OUT-1:8]};
            default: begin
                for (int i = 0; i < NUM_PIX; i++) begin
                    if (addr == 8'(A_PIX_BASE + 2 * i)) begin
                        rdata = {{PADF{1'b0}}, pr_rise[i]};
                    end
                    if (addr == 8'(A_PIX_BASE + 2 * i + 1)) begin
                        rdata = {{PADF{1'b0}}, pr_fall[i]};
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
    import ccd_tg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       reg_we,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       adclk,
    output logic       sh,
    output logic       led,
    output logic       rs1,
    output logic       rs2,
    output logic       shr,
    output logic       shs,
    output logic       h1,
    output logic       h2,
    output logic       clamp
);
    tg_state_e state, state_nx;
    logic      run;

    logic [FINE_W-1:0]              dot_per, pix_per, adc_rise, adc_fall;
    logic [LINE_W-1:0]              line_per, sh_rise, sh_fall, led_rise, led_fall;
    logic [NUM_OUT-1:0]             mask;
    logic [NUM_PIX-1:0][FINE_W-1:0] pr_rise, pr_fall;

    logic [FINE_W-1:0] dot_cnt, dot_act, pix_cnt, pix_act;
    logic [LINE_W-1:0] line_cnt, line_act;
    logic              dot_wrap, pix_wrap, line_wrap;
    logic [NUM_OUT-1:0] raw_q, outs;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (en)  state_nx = ST_RUN;
            ST_RUN:  if (!en) state_nx = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        run = 1'b0;
        unique case (state)
            ST_IDLE: run = 1'b0;
            ST_RUN:  run = 1'b1;
        endcase
    end

    ccd_tg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .dot_per(dot_per), .pix_per(pix_per), .line_per(line_per),
        .adc_rise(adc_rise), .adc_fall(adc_fall),
        .sh_rise(sh_rise), .sh_fall(sh_fall),
        .led_rise(led_rise), .led_fall(led_fall),
        .mask(mask), .pr_rise(pr_rise), .pr_fall(pr_fall)
    );

    ccd_tg_count #(.W(FINE_W)) u_dot (
        .clk(clk), .rst_n(rst_n), .run(run), .step(1'b1), .per_in(dot_per),
        .cnt(dot_cnt), .per_act(dot_act), .wrap(dot_wrap)
    );

    ccd_tg_count #(.W(FINE_W)) u_pix (
        .clk(clk), .rst_n(rst_n), .run(run), .step(1'b1), .per_in(pix_per),
        .cnt(pix_cnt), .per_act(pix_act), .wrap(pix_wrap)
    );

    ccd_tg_count #(.W(LINE_W)) u_line (
        .clk(clk), .rst_n(rst_n), .run(run), .step(pix_wrap), .per_in(line_per),
        .cnt(line_cnt), .per_act(line_act), .wrap(line_wrap)
    );

    ccd_tg_edge #(.W(FINE_W)) u_adc (
        .clk(clk), .rst_n(rst_n), .run(run), .cnt(dot_cnt),
        .rise(adc_rise), .fall(adc_fall), .q(raw_q[0])
    );

    ccd_tg_edge #(.W(LINE_W)) u_sh (
        .clk(clk), .rst_n(rst_n), .run(run), .cnt(line_cnt),
        .rise(sh_rise), .fall(sh_fall), .q(raw_q[1])
    );

    ccd_tg_edge #(.W(LINE_W)) u_led (
        .clk(clk), .rst_n(rst_n), .run(run), .cnt(line_cnt),
        .rise(led_rise), .fall(led_fall), .q(raw_q[2])
    );

    for (genvar gi = 0; gi < NUM_PIX; gi++) begin : g_pix_edge
        ccd_tg_edge #(.W(FINE_W)) u_pe (
            .clk(clk), .rst_n(rst_n), .run(run), .cnt(pix_cnt),
            .rise(pr_rise[gi]), .fall(pr_fall[gi]), .q(raw_q[3+gi])
        );
    end

    assign outs  = raw_q & ~mask & {NUM_OUT{run}};
    assign adclk = outs[0];
    assign sh    = outs[1];
    assign led   = outs[2];
    assign rs1   = outs[3];
    assign rs2   = outs[4];
    assign shr   = outs[5];
    assign shs   = outs[6];
    assign h1    = outs[7];
    assign h2    = outs[8];
    assign clamp = outs[9];
endmodule

// File: rtl/ccd_tg_checker.sv
module ccd_tg_checker
    import ccd_tg_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic               run,
    input logic [FINE_W-1:0]  dot_cnt,
    input logic [FINE_W-1:0]  dot_act,
    input logic               dot_wrap,
    input logic [FINE_W-1:0]  pix_cnt,
    input logic [FINE_W-1:0]  pix_act,
    input logic               pix_wrap,
    input logic [LINE_W-1:0]  line_cnt,
    input logic [LINE_W-1:0]  line_act,
    input logic [FINE_W-1:0]  adc_rise,
    input logic [FINE_W-1:0]  adc_fall,
    input logic               adc_q,
    input logic [NUM_OUT-1:0] pins
);
    p_dot_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dot_cnt <= dot_act);

    p_dot_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dot_wrap |=> (dot_cnt == '0));

    p_adc_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && en && dot_cnt == adc_rise && adc_rise != adc_fall) |=> adc_q);

    p_pix_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pix_cnt <= pix_act);

    p_line_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        line_cnt <= line_act);

    p_line_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && en && !pix_wrap) |=> $stable(line_cnt));

    p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !$past(en)) |-> (pins == '0));
endmodule

bind ccd_timing_gen ccd_tg_checker u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .run(run),
    .dot_cnt(dot_cnt), .dot_act(dot_act), .dot_wrap(dot_wrap),
    .pix_cnt(pix_cnt), .pix_act(pix_act), .pix_wrap(pix_wrap),
    .line_cnt(line_cnt), .line_act(line_act),
    .adc_rise(adc_rise), .adc_fall(adc_fall), .adc_q(raw_q[0]),
    .pins(outs)
);

// File: tb/sim_ccd_timing_gen.sv
module sim_ccd_timing_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic adclk, sh, led, rs1, rs2, shr, shs, h1, h2, clamp;
    logic [9:0] outs;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ccd_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .adclk(adclk), .sh(sh), .led(led), .rs1(rs1), .rs2(rs2),
        .shr(shr), .shs(shs), .h1(h1), .h2(h2), .clamp(clamp)
    );

    assign outs = {clamp, h2, h1, shs, shr, rs2, rs1, led, sh, adclk};

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input int exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, int'(reg_rdata), exp);
    endtask

    task automatic stop_run();
        @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic start_run(input int settle);
        @(negedge clk);
        en = 1'b1;
        repeat (settle) @(negedge clk);
    endtask

    task automatic count_hi(input int b, input int n, output int hi, output int rises);
        int prev;
        prev = int'(outs[b]);
        hi = 0; rises = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (outs[b]) hi++;
            if (outs[b] && prev == 0) rises++;
            prev = int'(outs[b]);
        end
    endtask

    task automatic gap(input int b, output int n);
        int prev;
        prev = int'(outs[b]);
        n = 0;
        while (n < 5000) begin
            @(negedge clk);
            reg_we = 1'b0;
            n++;
            if (outs[b] && prev == 0) break;
            prev = int'(outs[b]);
        end
    endtask

    task automatic t_reset();
        check("R1 outputs", int'(outs), 0);
        rd("R1 dot period", 8'h00, 0);
        rd("R1 line hi", 8'h02, 0);
        rd("R1 mask lo", 8'h0E, 0);
        rd("R1 clamp fall", 8'h1D, 0);
    endtask

    task automatic t_regmap();
        wr(8'h00, 8'hFF);
        rd("R2 6-bit reserved bits", 8'h00, 8'h3F);
        wr(8'h15, 8'hC5);
        rd("R2 SHR fall 6-bit", 8'h15, 8'h05);
        rd("R2 unmapped", 8'h40, 0);
        wr(8'h0F, 8'hFF);
        rd("R8 mask hi upper bits", 8'h0F, 8'h03);
        wr(8'h00, 8'h00);
        wr(8'h15, 8'h00);
        wr(8'h0F, 8'h00);
    endtask

    task automatic t_dot();
        int hi, ri;
        stop_run();
        wr(8'h00, 8'd3);
        wr(8'h04, 8'd0);
        wr(8'h05, 8'd2);
        start_run(12);
        count_hi(0, 40, hi, ri);
        check("R3 ADCLK high cycles", hi, 20);
        check("R3 ADCLK pulses", ri, 10);
    endtask

    task automatic t_pixel();
        int hi, ri;
        stop_run();
        wr(8'h01, 8'd4);
        wr(8'h10, 8'd1); wr(8'h11, 8'd3);   // RS1 inside period
        wr(8'h18, 8'd0); wr(8'h19, 8'd4);   // H1 near full duty
        wr(8'h1C, 8'd3); wr(8'h1D, 8'd1);   // CLAMP across wrap
        wr(8'h12, 8'd2); wr(8'h13, 8'd2);   // RS2 equal positions
        start_run(12);
        count_hi(3, 50, hi, ri);
        check("R4 RS1 high cycles", hi, 20);
        count_hi(7, 50, hi, ri);
        check("R4 H1 high cycles", hi, 40);
        count_hi(9, 50, hi, ri);
        check("R4 CLAMP wrap-spanning high cycles", hi, 30);
        count_hi(4, 50, hi, ri);
        check("R6 RS2 equal rise/fall", hi, 0);
    endtask

    task automatic t_mask();
        int hi, ri;
        wr(8'h0E, 8'h08);
        count_hi(3, 50, hi, ri);
        check("R8 masked RS1", hi, 0);
        count_hi(0, 40, hi, ri);
        check("R8 unmasked ADCLK", hi, 20);
        wr(8'h0F, 8'h02);
        count_hi(9, 50, hi, ri);
        check("R8 masked CLAMP", hi, 0);
        wr(8'h0E, 8'h00);
        wr(8'h0F, 8'h00);
    endtask

    task automatic t_line();
        int hi, ri;
        stop_run();
        wr(8'h01, 8'd1);
        wr(8'h02, 8'd0); wr(8'h03, 8'd9);
        wr(8'h0A, 8'd0); wr(8'h0B, 8'd2);
        wr(8'h0C, 8'd0); wr(8'h0D, 8'd5);
        wr(8'h06, 8'd0); wr(8'h07, 8'd0);
        wr(8'h08, 8'd0); wr(8'h09, 8'd1);
        start_run(25);
        count_hi(2, 100, hi, ri);
        check("R5 LED high cycles", hi, 30);
        count_hi(1, 100, hi, ri);
        check("R5 SH high cycles", hi, 10);
    endtask

    task automatic t_line_hi();
        int n;
        stop_run();
        wr(8'h01, 8'd0);
        wr(8'h02, 8'd1); wr(8'h03, 8'd0);
        start_run(2);
        gap(1, n);
        gap(1, n);
        check("R5 257-pixel line via high byte", n, 257);
    endtask

    task automatic t_disable_restart();
        stop_run();
        check("R9 outputs low when disabled", int'(outs), 0);
        wr(8'h01, 8'd4);
        wr(8'h10, 8'd0); wr(8'h11, 8'd1);
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        check("R9 RS1 after first edge", int'(rs1), 0);
        @(negedge clk);
        check("R9 RS1 one clock after count 0", int'(rs1), 1);
        @(negedge clk);
        check("R3 RS1 clears after fall match", int'(rs1), 0);
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R9 outputs low two clocks after en falls", int'(outs), 0);
    endtask

    task automatic t_shadow();
        int n;
        start_run(3);
        gap(3, n);
        gap(3, n);
        check("R7 steady RS1 interval", n, 5);
        reg_we = 1'b1; reg_addr = 8'h01; reg_wdata = 8'd9;
        gap(3, n);
        check("R7 old period completes", n, 5);
        gap(3, n);
        check("R7 new period after wrap", n, 10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_dot();
        t_pixel();
        t_mask();
        t_line();
        t_line_hi();
        t_disable_restart();
        t_shadow();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule